// File: doc/BRIEF.md
# Multiprocessor Shared-Bus Arbiter

This block decides which of up to six processors, or one host, drives a shared external bus. Each processor has a request line and a grant line. The host has its own request and grant pair. Processor `k` (index 0 to 5) carries the bus identity `k+1`, so the six processors use the three-bit codes 001 to 110. The host uses the code 000. At any time at most one grant is high, and `master_id` reports the identity of the master that holds the grant.

The master holds the bus for as long as its request stays high. It gives the bus up by dropping its request, or, for a processor, by pulsing `yield_req`. At the moment of release the next owner is chosen as follows:

- A waiting host always wins.
- Otherwise a processor is picked under one of two schemes, selected at run time by `rot_mode`:
  - Fixed priority: the lowest ID wins.
  - Rotating priority: the search starts just after the processor that releases the bus.

Every change of master costs exactly one cycle in which nothing is granted. While `lock` is high, the owning master cannot lose the bus, so semaphore read-modify-write sequences stay indivisible. If nobody else is asking, the last master stays parked on the bus.

Top module: `mp_bus_arbiter`

## Requirements
- R1: After reset, processor index 0 holds a parked grant. `proc_grant` is 000001, `master_id` is 001 and `host_grant` is low.
- R2: At most one of the seven grant outputs (six processor grants and the host grant) is high in any cycle.
- R3: A release decision happens at a clock edge. In the cycle that follows it, all grants are low. At the next edge the chosen master is granted. The master therefore changes with exactly one idle cycle.
- R4: With `rot_mode`=0, the winning processor is the requesting processor with the lowest index, that is, the lowest ID.
- R5: With `rot_mode`=1, requesters are searched in increasing index order, wrapping from 5 to 0. The search starts at the index after the processor that owned the bus most recently. That processor therefore has the lowest priority.
- R6: A processor master whose request stays high and whose `yield_req` is low keeps its grant, whatever other processors or the host request.
- R7: A processor master that raises `yield_req` releases the bus even if its request is still high. It is excluded from that decision.
- R8: While `lock` is high and the arbiter is not in its idle changeover cycle, the grants do not change at the next edge, even if the master drops its request.
- R9: When the bus is released and `host_req` is high, the host wins over every processor. While the host owns the bus, `master_id` is 000. The host keeps the bus until it drops `host_req`.
- R10: When the master releases and no other party requests, the grant stays on that master (parked). The grant then moves with one idle cycle as soon as another party requests.
- R11: `master_id` changes in the same cycle as the grants. While a processor grant is high, `master_id` equals its index plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rot_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| proc_req | input | NPROC | Bus request, one bit per processor |
| yield_req | input | 1 | Current processor master gives up the bus |
| host_req | input | 1 | Host bus request |
| lock | input | 1 | Hold the current master, blocks rearbitration |
| proc_grant | output | NPROC | One-hot processor grant |
| host_grant | output | 1 | Host grant |
| master_id | output | IDW | Identity of the current master (000 = host) |

## Verification
The main sweep runs in both priority modes. It drives every one of the 64 processor request patterns in turn, and the outgoing master always drops its own bit. In fixed mode this separates lowest-ID selection from any order-dependent scheme. In rotating mode it shows that the search starts from whichever master released last, because the starting owner differs from pattern to pattern. Patterns with no other requester tell parking apart from a wrongful changeover. Directed sequences then cover:

- holding a master while its request stays high;
- dropping the request under `lock`;
- yielding while still requesting;
- a host request arriving while processors compete.

These show the hold, lock, yield and host-precedence rules separately from the priority choice.

// File: rtl/mparb_pkg.sv
package mparb_pkg;

  typedef enum logic {PH_OWN = 1'b0, PH_TURN = 1'b1} phase_e;

  // Index after i, wrapping within a ring of n slots.
  function automatic int next_slot(input int i, input int n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

  // Bus identity carried by processor index i (host uses zero).
  function automatic int proc_ident(input int i);
    return i + 1;
  endfunction

endpackage

// File: rtl/mparb_pick.sv
module mparb_pick
  import mparb_pkg::*;
#(
  parameter int NPROC = 6,
  parameter int IW    = 3
) (
  input  logic [NPROC-1:0] cand,
  input  logic             rot_mode,
  input  logic [IW-1:0]    last_idx,
  output logic             found,
  output logic [IW-1:0]    win_idx
);

  int start_pos;

  always_comb begin
    start_pos = rot_mode ? next_slot(int'(last_idx), NPROC) : 0;
    found     = 1'b0;
    win_idx   = '0;
    // Scan from the far end back so the nearest candidate to start_pos is kept.
    for (int k = NPROC - 1; k >= 0; k--) begin
      automatic int idx = (start_pos + k) % NPROC;
      if (cand[idx]) begin
        found   = 1'b1;
        win_idx = IW'(idx);
      end
    end
  end

endmodule

// File: rtl/mparb_decode.sv
module mparb_decode
  import mparb_pkg::*;
#(
  parameter int NPROC = 6,
  parameter int IW    = 3,
  parameter int IDW   = 3
) (
  input  logic             in_turn,
  input  logic             host_own,
  input  logic [IW-1:0]    cur_idx,
  output logic [NPROC-1:0] proc_grant,
  output logic             host_grant,
  output logic [IDW-1:0]   master_id
);

  genvar g;
  generate
    for (g = 0; g < NPROC; g++) begin : g_grant
      assign proc_grant[g] = !in_turn && !host_own && (cur_idx == IW'(g));
    end
  endgenerate

  assign host_grant = !in_turn && host_own;
  assign master_id  = host_own ? '0 : IDW'(proc_ident(int'(cur_idx)));

endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter
  import mparb_pkg::*;
#(
  parameter int NPROC = 6,
  parameter int IDW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rot_mode,
  input  logic [NPROC-1:0] proc_req,
  input  logic             yield_req,
  input  logic             host_req,
  input  logic             lock,
  output logic [NPROC-1:0] proc_grant,
  output logic             host_grant,
  output logic [IDW-1:0]   master_id
);

  localparam int IW = (NPROC > 1) ? $clog2(NPROC) : 1;

  phase_e          phase;
  logic            host_own;
  logic [IW-1:0]   cur_idx;
  logic            pend_host;
  logic [IW-1:0]   pend_idx;

  // Named internal events
  logic             in_turn;
  logic             owner_holds;
  logic             release_now;
  logic             host_claim;
  logic [NPROC-1:0] cand;
  logic             found;
  logic [IW-1:0]    win_idx;
  logic             handover;

  assign in_turn     = (phase == PH_TURN);
  assign owner_holds = host_own ? host_req : (proc_req[cur_idx] && !yield_req);
  assign release_now = !in_turn && !lock && !owner_holds;
  assign host_claim  = host_req && !host_own;
  assign cand        = host_own ? proc_req
                                : (proc_req & ~(NPROC'(1) << cur_idx));
  assign handover    = release_now && (host_claim || found);

  mparb_pick #(.NPROC(NPROC), .IW(IW)) u_pick (
    .cand     (cand),
    .rot_mode (rot_mode),
    .last_idx (cur_idx),
    .found    (found),
    .win_idx  (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OWN;
      host_own  <= 1'b0;
      cur_idx   <= '0;
      pend_host <= 1'b0;
      pend_idx  <= '0;
    end else if (in_turn) begin
      phase    <= PH_OWN;
      host_own <= pend_host;
      if (!pend_host) cur_idx <= pend_idx;
    end else if (handover) begin
      phase     <= PH_TURN;
      pend_host <= host_claim;
      pend_idx  <= win_idx;
    end
  end

  mparb_decode #(.NPROC(NPROC), .IW(IW), .IDW(IDW)) u_dec (
    .in_turn    (in_turn),
    .host_own   (host_own),
    .cur_idx    (cur_idx),
    .proc_grant (proc_grant),
    .host_grant (host_grant),
    .master_id  (master_id)
  );

endmodule

// File: rtl/mp_bus_arbiter_chk.sv
module mp_bus_arbiter_chk #(
  parameter int NPROC = 6,
  parameter int IDW   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPROC-1:0] proc_req,
  input logic             yield_req,
  input logic             host_req,
  input logic             lock,
  input logic [NPROC-1:0] proc_grant,
  input logic             host_grant,
  input logic [IDW-1:0]   master_id,
  input logic             in_turn
);

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_grant, proc_grant}));

  assert_idle_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_turn |-> (proc_grant == '0 && !host_grant));

  assert_turn_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_turn |=> (|{host_grant, proc_grant}));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_turn && |(proc_grant & proc_req) && !yield_req) |=> $stable(proc_grant));

  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !in_turn) |=> ($stable(proc_grant) && $stable(host_grant)));

  assert_host_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_grant && host_req) |=> host_grant);

  assert_host_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> (master_id == '0));

  assert_proc_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|proc_grant) |-> (proc_grant == (NPROC'(1) << (master_id - IDW'(1)))));

endmodule

bind mp_bus_arbiter mp_bus_arbiter_chk #(.NPROC(NPROC), .IDW(IDW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .proc_req   (proc_req),
  .yield_req  (yield_req),
  .host_req   (host_req),
  .lock       (lock),
  .proc_grant (proc_grant),
  .host_grant (host_grant),
  .master_id  (master_id),
  .in_turn    (in_turn)
);

// File: tb/mp_bus_arbiter_test.sv
module mp_bus_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rot_mode = 1'b0;
  logic [NP-1:0] proc_req = '0;
  logic          yield_req = 1'b0;
  logic          host_req = 1'b0;
  logic          lock = 1'b0;
  logic [NP-1:0] proc_grant;
  logic          host_grant;
  logic [2:0]    master_id;

  int checks = 0;
  int fails  = 0;
  int own    = 0;   // bench view of the processor that owns or last owned the bus

  always #(CLK_PERIOD/2) clk = ~clk;

  mp_bus_arbiter #(.NPROC(NP), .IDW(3)) uut (
    .clk(clk), .rst_n(rst_n), .rot_mode(rot_mode), .proc_req(proc_req),
    .yield_req(yield_req), .host_req(host_req), .lock(lock),
    .proc_grant(proc_grant), .host_grant(host_grant), .master_id(master_id)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected winner: lowest set index, or the first set index after 'last' going round.
  function automatic int expect_win(input logic [NP-1:0] c, input bit rot, input int last);
    if (!rot) begin
      for (int i = 0; i < NP; i++) if (c[i]) return i;
    end else begin
      for (int d = 1; d <= NP; d++) if (c[(last + d) % NP]) return (last + d) % NP;
    end
    return -1;
  endfunction

  task automatic expect_proc(input int p, input string req);
    chk(proc_grant == NP'(1 << p) && !host_grant, req, int'(proc_grant), 1 << p);
    chk(master_id == 3'(p + 1), "R11 id", int'(master_id), p + 1);
  endtask

  task automatic expect_idle(input string req);
    chk(proc_grant == '0 && !host_grant, req, int'({host_grant, proc_grant}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    expect_proc(0, "R1 reset grant");
    chk(host_grant == 1'b0, "R1 host low", int'(host_grant), 0);

    // R4/R5/R3/R10 sweep over every request pattern in both modes
    for (int m = 0; m < 2; m++) begin
      rot_mode = m[0];
      for (int pat = 0; pat < 64; pat++) begin
        automatic logic [NP-1:0] c = NP'(pat) & ~NP'(1 << own);
        proc_req = c;
        if (c == '0) begin
          @(negedge clk);
          expect_proc(own, "R10 parked");
          @(negedge clk);
          expect_proc(own, "R10 parked");
        end else begin
          automatic int w = expect_win(c, m[0], own);
          @(negedge clk);
          expect_idle("R3 idle changeover");
          @(negedge clk);
          expect_proc(w, m[0] ? "R5 rotating winner" : "R4 fixed winner");
          own = w;
        end
      end
    end

    // R6: master holding its request keeps the bus against others and the host
    rot_mode = 1'b0;
    proc_req = NP'(1 << own) | 6'b111111;
    host_req = 1'b1;
    repeat (3) begin
      @(negedge clk);
      expect_proc(own, "R6 hold");
    end
    host_req = 1'b0;

    // R8: lock keeps the master after it drops its request
    lock = 1'b1;
    proc_req = 6'b111111 & ~NP'(1 << own);
    repeat (3) begin
      @(negedge clk);
      expect_proc(own, "R8 lock hold");
    end
    lock = 1'b0;
    @(negedge clk);
    expect_idle("R3 idle after lock");
    @(negedge clk);
    own = expect_win(6'b111111 & ~NP'(1 << own), 1'b0, own);
    expect_proc(own, "R8 release after lock");

    // R7: yield while still requesting, own bit excluded
    proc_req = 6'b000011 | NP'(1 << own);
    yield_req = 1'b1;
    @(negedge clk);
    yield_req = 1'b0;
    expect_idle("R7 idle after yield");
    @(negedge clk);
    own = expect_win((6'b000011 | NP'(1 << own)) & ~NP'(1 << own), 1'b0, own);
    expect_proc(own, "R7 yield winner");

    // R9: host wins at release over processors, keeps bus, id 000
    host_req = 1'b1;
    proc_req = 6'b111111 & ~NP'(1 << own);
    @(negedge clk);
    expect_idle("R3 idle to host");
    @(negedge clk);
    chk(host_grant && proc_grant == '0, "R9 host granted", int'({host_grant, proc_grant}), 64);
    chk(master_id == 3'd0, "R9 host id", int'(master_id), 0);
    proc_req = 6'b111111;
    repeat (3) begin
      @(negedge clk);
      chk(host_grant == 1'b1, "R9 host keeps", int'(host_grant), 1);
    end
    // Host drops: rotating search starts after last processor owner
    rot_mode = 1'b1;
    host_req = 1'b0;
    @(negedge clk);
    expect_idle("R3 idle from host");
    @(negedge clk);
    own = expect_win(6'b111111, 1'b1, own);
    expect_proc(own, "R5 after host");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule